// File: doc/BRIEF.md
# Posit Word Field Unpacker

This block takes one posit word of `WORD_W` bits with `EXP_W` exponent bits and splits it into the pieces an arithmetic datapath works with: a sign, a signed scale factor (regime and exponent combined), and a left-aligned fraction with the hidden one made explicit. Two flags mark the two special encodings, zero and Not-a-Real. Negative words are turned into their two's-complement magnitude before the fields are pulled out, and the sign is reported on its own.

The hard part is that the regime is a run of identical bits whose length depends on the data, so the exponent and fraction have no fixed position. The unpacker counts that leading run and shifts the tail of the word so that the exponent and fraction land at fixed positions. The decode itself is combinational. A parameter chooses whether an output register follows it. With the register present, a result appears one clock after its `in_valid` strobe and is held while no new word arrives.

Top module: `posit_unpack`

## Requirements
- R1: An input word of all zero bits gives `out_zero`=1, `out_nar`=0, `out_sign`=0, `out_scale`=0 and `out_frac`=0.
- R2: An input word with only its top bit set gives `out_nar`=1, `out_zero`=0, `out_sign`=1, `out_scale`=0 and `out_frac`=0.
- R3: `out_sign` equals the top bit of the word. A word with the top bit set decodes to the same scale and fraction as its two's complement.
- R4: The regime run starts at the bit just below the sign and ends at the first bit of opposite value, or at the end of the word. A run of m ones gives regime m-1. A run of m zeros gives regime -m.
- R5: `out_scale` is a signed value that equals regime * 2^EXP_W + exponent. The regime occupies the upper bits and the EXP_W exponent bits the lower bits. The exponent is the EXP_W bits after the terminating bit, most significant first.
- R6: Exponent or fraction bits that would fall past the end of the word read as zero.
- R7: `out_frac` is WORD_W-2-EXP_W bits wide. For a word that is neither zero nor Not-a-Real, its top bit is the hidden 1. The bits below hold the fraction bits in word order, left-aligned and padded with zeros.
- R8: With OUT_REG=1, a word presented with `in_valid`=1 at a rising edge appears on the outputs after that edge, with `out_valid`=1. A cycle with `in_valid`=0 gives `out_valid`=0 after the next edge, and the data outputs keep their last values.
- R9: When `rst_n` is low at a rising edge, the next state has `out_valid` and all data outputs cleared to zero.
- R10: `out_zero` and `out_nar` are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks `in_word` as carrying a word to unpack |
| in_word | input | WORD_W | Posit word |
| out_valid | output | 1 | Outputs carry a fresh result |
| out_sign | output | 1 | Sign of the word |
| out_scale | output | $clog2(WORD_W)+1+EXP_W | Signed scale factor |
| out_frac | output | WORD_W-2-EXP_W | Fraction with explicit hidden bit at the top |
| out_zero | output | 1 | Word is the zero pattern |
| out_nar | output | 1 | Word is the Not-a-Real pattern |

## Verification
Every 8-bit word with one exponent bit is decoded and compared with a bit-by-bit reference. This covers every regime length from one bit to the whole word, both run polarities, and every negative word beside its positive twin. Hand-worked words are checked separately:
- A one-bit regime with a full fraction tests the exponent and fraction alignment.
- Words whose run reaches the last bit test the regime limit and the zero padding of the missing exponent.
- Words just below the run-to-end case test an exponent that survives while the fraction is gone.

Back-to-back and gapped streams tell apart a register that updates on every strobe from one that holds during idle cycles. A reset in the middle of a stream tests the clearing of the outputs.

// File: rtl/posit_pkg.sv
// Package: posit_pkg
// Shared types and width helpers for the posit unpacker.
// Assumes parameters are legal (checked by the top module).
package posit_pkg;

    // Classification of a raw posit word.
    typedef enum logic [1:0] {
        CLASS_REAL = 2'd0,
        CLASS_ZERO = 2'd1,
        CLASS_NAR  = 2'd2
    } word_class_e;

    // Width of a counter able to hold a regime run of up to word_w-1.
    function automatic int run_width(input int word_w);
        return $clog2(word_w);
    endfunction

    // Signed width of the regime value, range -(word_w-1) .. word_w-2.
    function automatic int regime_width(input int word_w);
        return $clog2(word_w) + 1;
    endfunction

endpackage

// File: rtl/posit_magnitude.sv
// Module: posit_magnitude
// Produces the body (all bits below the sign) of the word's magnitude.
// For a negative word this is the low part of its two's complement,
// which equals the low bits of the full negation.
// Assumes WORD_W >= 3. Purely combinational.
module posit_magnitude #(
    parameter int WORD_W = 8,
    localparam int BODY_W = WORD_W - 1
) (
    input  logic [WORD_W-1:0] word,
    output logic              sign,
    output logic [BODY_W-1:0] body
);

    // Split off the sign and negate the body when the word is negative.
    always_comb begin
        sign = word[WORD_W-1];
        if (sign)
            body = (~word[BODY_W-1:0]) + BODY_W'(1);
        else
            body = word[BODY_W-1:0];
    end

endmodule

// File: rtl/posit_run_count.sv
// Module: posit_run_count
// Measures the regime run: the number of leading body bits equal to the
// top body bit. The result is 1 .. BODY_W; it equals BODY_W when the run
// reaches the end of the word. Assumes a body that is not all zeros
// (zero and Not-a-Real are flagged elsewhere). Purely combinational.
module posit_run_count #(
    parameter int WORD_W = 8,
    localparam int BODY_W = WORD_W - 1,
    localparam int CNT_W  = posit_pkg::run_width(WORD_W)
) (
    input  logic [BODY_W-1:0] body,
    output logic              polarity,
    output logic [CNT_W-1:0]  run_len
);

    logic found;

    // Scan from the top for the first bit that breaks the run.
    always_comb begin
        polarity = body[BODY_W-1];
        run_len  = CNT_W'(BODY_W);
        found    = 1'b0;
        for (int i = BODY_W - 2; i >= 0; i--) begin
            if (!found && (body[i] != polarity)) begin
                run_len = CNT_W'(BODY_W - 1 - i);
                found   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/posit_field_align.sv
// Module: posit_field_align
// Removes the regime and its terminating bit, leaving the exponent and
// fraction left-aligned in a TAIL_W-bit vector. The top two body bits are
// always consumed (run of at least one plus terminator), so only the lower
// TAIL_W bits are shifted, by run_len-1. Bits shifted in are zero, which
// pads any exponent or fraction cut off by the word end.
// Assumes run_len >= 1. Purely combinational.
module posit_field_align #(
    parameter int WORD_W = 8,
    localparam int BODY_W = WORD_W - 1,
    localparam int TAIL_W = WORD_W - 3,
    localparam int CNT_W  = posit_pkg::run_width(WORD_W)
) (
    input  logic [BODY_W-1:0] body,
    input  logic [CNT_W-1:0]  run_len,
    output logic [TAIL_W-1:0] tail
);

    logic [CNT_W-1:0] shamt;

    // Shift the bits after the minimal regime past the rest of the run.
    always_comb begin
        shamt = run_len - CNT_W'(1);
        tail  = body[TAIL_W-1:0] << shamt;
    end

endmodule

// File: rtl/posit_unpack.sv
// Module: posit_unpack
// Unpacks a WORD_W-bit posit with EXP_W exponent bits into sign, signed
// scale factor {regime, exponent}, and a fraction with explicit hidden bit.
// Flags zero and Not-a-Real; both force scale and fraction to zero.
// OUT_REG=1 adds an output register (1-cycle latency, holds while idle);
// OUT_REG=0 makes the block purely combinational.
// Assumes WORD_W >= EXP_W + 4 so at least one fraction bit exists.
module posit_unpack #(
    parameter int WORD_W  = 8,
    parameter int EXP_W   = 1,
    parameter bit OUT_REG = 1'b1,
    localparam int BODY_W  = WORD_W - 1,
    localparam int TAIL_W  = WORD_W - 3,
    localparam int FRAC_W  = TAIL_W - EXP_W,
    localparam int FOUT_W  = FRAC_W + 1,
    localparam int CNT_W   = posit_pkg::run_width(WORD_W),
    localparam int RG_W    = posit_pkg::regime_width(WORD_W),
    localparam int SCALE_W = RG_W + EXP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_word,
    output logic               out_valid,
    output logic               out_sign,
    output logic [SCALE_W-1:0] out_scale,
    output logic [FOUT_W-1:0]  out_frac,
    output logic               out_zero,
    output logic               out_nar
);

    import posit_pkg::*;

    // Parameter legality check at elaboration.
    initial begin
        if (WORD_W < EXP_W + 4)
            $error("posit_unpack: WORD_W must be at least EXP_W + 4");
    end

    logic                sign_c;
    logic [BODY_W-1:0]   body_c;
    logic                pol_c;
    logic [CNT_W-1:0]    run_c;
    logic [TAIL_W-1:0]   tail_c;
    logic signed [RG_W-1:0] regime_c;
    logic [SCALE_W-1:0]  scale_c;
    logic [FOUT_W-1:0]   frac_c;
    word_class_e         class_c;

    posit_magnitude #(.WORD_W(WORD_W)) u_mag (
        .word (in_word),
        .sign (sign_c),
        .body (body_c)
    );

    posit_run_count #(.WORD_W(WORD_W)) u_run (
        .body     (body_c),
        .polarity (pol_c),
        .run_len  (run_c)
    );

    posit_field_align #(.WORD_W(WORD_W)) u_align (
        .body    (body_c),
        .run_len (run_c),
        .tail    (tail_c)
    );

    // Classify the raw word: all low bits clear means zero or Not-a-Real.
    always_comb begin
        if (in_word[BODY_W-1:0] != '0)
            class_c = CLASS_REAL;
        else if (in_word[WORD_W-1])
            class_c = CLASS_NAR;
        else
            class_c = CLASS_ZERO;
    end

    // Turn the run length into a signed regime value.
    always_comb begin
        if (pol_c)
            regime_c = $signed({1'b0, run_c}) - RG_W'(1);
        else
            regime_c = -$signed({1'b0, run_c});
    end

    // Form the scale factor; the exponent field exists only when EXP_W > 0.
    generate
        if (EXP_W > 0) begin : g_exp
            logic [SCALE_W-1:0] joined;
            // Place the regime above the exponent bits.
            always_comb joined = {regime_c, tail_c[TAIL_W-1 -: EXP_W]};
            // Zero the scale for special words.
            always_comb scale_c = (class_c == CLASS_REAL) ? joined : '0;
        end else begin : g_noexp
            // Scale is the regime alone; zero for special words.
            always_comb scale_c = (class_c == CLASS_REAL) ? SCALE_W'(regime_c) : '0;
        end
    endgenerate

    // Attach the hidden one to the fraction; zero for special words.
    always_comb begin
        if (class_c == CLASS_REAL)
            frac_c = {1'b1, tail_c[FRAC_W-1:0]};
        else
            frac_c = '0;
    end

    // Output stage: register or pass-through, chosen by OUT_REG.
    generate
        if (OUT_REG) begin : g_reg
            // Capture a decoded word on a strobe, hold otherwise, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid <= 1'b0;
                    out_sign  <= 1'b0;
                    out_scale <= '0;
                    out_frac  <= '0;
                    out_zero  <= 1'b0;
                    out_nar   <= 1'b0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) begin
                        out_sign  <= sign_c;
                        out_scale <= scale_c;
                        out_frac  <= frac_c;
                        out_zero  <= (class_c == CLASS_ZERO);
                        out_nar   <= (class_c == CLASS_NAR);
                    end
                end
            end

            // R8: a strobe yields a valid result one edge later
            a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            // R8: an idle cycle yields no result and leaves the data untouched
            a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> (!out_valid && $stable(out_scale) && $stable(out_frac)));
            // R9: reset clears the output register
            a_r9_reset_clears: assert property (@(posedge clk)
                !rst_n |=> (!out_valid && out_scale == '0 && out_frac == '0
                            && !out_zero && !out_nar && !out_sign));
            // R3: reported sign is the top bit of the captured word
            a_r3_sign_from_word: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> out_sign == $past(in_word[WORD_W-1]));
        end else begin : g_comb
            // Pass the decode straight through.
            always_comb begin
                out_valid = in_valid;
                out_sign  = sign_c;
                out_scale = scale_c;
                out_frac  = frac_c;
                out_zero  = (class_c == CLASS_ZERO);
                out_nar   = (class_c == CLASS_NAR);
            end
        end
    endgenerate

    // R1: zero result carries no sign, scale or fraction
    a_r1_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_zero) |-> (!out_sign && out_scale == '0 && out_frac == '0));
    // R2: Not-a-Real result is negative with empty fields
    a_r2_nar_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_nar) |-> (out_sign && out_scale == '0 && out_frac == '0));
    // R10: the two special flags are exclusive
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_zero && out_nar));
    // R7: every real result carries the hidden one
    a_r7_hidden_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_zero && !out_nar) |-> out_frac[FOUT_W-1]);
    // R4: the run counter stays within one bit to the whole body
    a_r4_run_range: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && class_c == CLASS_REAL) |-> (run_c >= CNT_W'(1) && run_c <= CNT_W'(BODY_W)));

endmodule

// File: tb/posit_unpack_tb.sv
// Bench: scoreboard for posit_unpack (WORD_W=8, EXP_W=1, registered output).
// Driver pushes expected results, monitor compares them as they emerge.
module posit_unpack_tb;

    localparam int N   = 8;
    localparam int ES  = 1;
    localparam int FW  = N - 3 - ES;
    localparam int SW  = $clog2(N) + 1 + ES;

    typedef struct {
        bit    sign;
        int    scale;
        int    frac;
        bit    zero;
        bit    nar;
        string tag;
        logic [N-1:0] word;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [N-1:0]  in_word = '0;
    logic          out_valid;
    logic          out_sign;
    logic [SW-1:0] out_scale;
    logic [FW:0]   out_frac;
    logic          out_zero;
    logic          out_nar;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    posit_unpack #(.WORD_W(N), .EXP_W(ES), .OUT_REG(1'b1)) u_dut (
        .clk, .rst_n, .in_valid, .in_word,
        .out_valid, .out_sign, .out_scale, .out_frac, .out_zero, .out_nar
    );

    // Bit-serial reference decode written from the requirements.
    function automatic exp_t ref_decode(input logic [N-1:0] w);
        exp_t r;
        logic [N-1:0] a;
        int i, m, k, e, f;
        bit p, cut;
        r.word = w; r.sign = w[N-1]; r.zero = 0; r.nar = 0;
        r.scale = 0; r.frac = 0; r.tag = "R5";
        if (w == '0) begin r.zero = 1; r.tag = "R1"; return r; end
        if (w == {1'b1, {(N-1){1'b0}}}) begin r.nar = 1; r.tag = "R2"; return r; end
        a = w[N-1] ? (~w + 1'b1) : w;
        p = a[N-2]; i = N - 2; m = 0;
        while (i >= 0 && a[i] == p) begin m++; i--; end
        k = p ? m - 1 : -m;
        i--;
        e = 0; cut = 0;
        for (int j = 0; j < ES; j++) begin
            if (i < 0) cut = 1;
            e = (e << 1) | ((i >= 0) ? int'(a[i]) : 0);
            i--;
        end
        f = 0;
        for (int j = 0; j < FW; j++) begin
            f = (f << 1) | ((i >= 0) ? int'(a[i]) : 0);
            i--;
        end
        r.scale = k * (1 << ES) + e;
        r.frac = (1 << FW) | f;
        if (w[N-1]) r.tag = "R3";
        else if (m == N - 1) r.tag = "R4";
        else if (cut) r.tag = "R6";
        else r.tag = "R7";
        return r;
    endfunction

    // Driver: present one word for a cycle and queue its expected result.
    task automatic drive(input logic [N-1:0] w, input exp_t e);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Build an expected item by hand.
    function automatic exp_t mk(input logic [N-1:0] w, input bit s, input int sc,
                                input int fr, input string tag);
        exp_t r;
        r.word = w; r.sign = s; r.scale = sc; r.frac = fr;
        r.zero = 0; r.nar = 0; r.tag = tag;
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Monitor: compare each valid result with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R8", "unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                int sc;
                e = sb.pop_front();
                sc = int'($signed(out_scale));
                check(out_sign == e.sign, e.tag, $sformatf("sign w=%02h", e.word), out_sign, e.sign);
                check(sc == e.scale, e.tag, $sformatf("scale w=%02h", e.word), sc, e.scale);
                check(int'(out_frac) == e.frac, e.tag, $sformatf("frac w=%02h", e.word), int'(out_frac), e.frac);
                check(out_zero == e.zero, e.tag, $sformatf("zero w=%02h", e.word), out_zero, e.zero);
                check(out_nar == e.nar, e.tag, $sformatf("nar w=%02h", e.word), out_nar, e.nar);
                check(!(out_zero && out_nar), "R10", "flags both set", 1, 0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [SW-1:0] held_scale;
        logic [FW:0]   held_frac;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(out_valid == 0 && out_scale == 0 && out_frac == 0 && !out_zero && !out_nar,
              "R9", "reset state", int'(out_frac), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed words (field positions as stated in R4..R7).
        drive(8'h40, mk(8'h40, 0, 0, 16, "R7"));     // regime 0, frac 1.0000
        drive(8'h5B, mk(8'h5B, 0, 1, 27, "R5"));     // regime 0, exp 1, frac 1.1011
        drive(8'h01, mk(8'h01, 0, -12, 16, "R4"));   // run of six zeros
        drive(8'h7F, mk(8'h7F, 0, 12, 16, "R4"));    // run of ones to the end
        drive(8'h7E, mk(8'h7E, 0, 10, 16, "R6"));    // exponent cut off
        drive(8'h03, mk(8'h03, 0, -9, 16, "R6"));    // exponent kept, fraction gone
        drive(8'hC0, mk(8'hC0, 1, 0, 16, "R3"));     // negative twin of 0x40
        drive(8'hA5, mk(8'hA5, 1, 1, 27, "R3"));     // negative twin of 0x5B
        drive(8'h00, ref_decode(8'h00));             // R1
        drive(8'h80, ref_decode(8'h80));             // R2
        idle();

        // R8: idle cycle leaves data held and valid low.
        @(negedge clk);
        held_scale = out_scale;
        held_frac  = out_frac;
        idle();
        @(negedge clk);
        check(!out_valid, "R8", "valid during idle", out_valid, 0);
        check(out_scale == held_scale && out_frac == held_frac, "R8", "hold during idle",
              int'(out_frac), int'(held_frac));

        // Exhaustive sweep, back-to-back.
        for (int w = 0; w < (1 << N); w++) drive(N'(w), ref_decode(N'(w)));
        // Gapped stream.
        for (int w = 0; w < (1 << N); w += 7) begin
            drive(N'(w), ref_decode(N'(w)));
            idle();
        end
        idle();
        idle();

        // R9: reset in the middle of a stream clears the outputs.
        drive(8'h5B, mk(8'h5B, 0, 1, 27, "R5"));
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        void'(sb.pop_front());
        @(negedge clk);
        check(!out_valid && out_scale == 0 && out_frac == 0 && !out_sign, "R9", "mid-stream reset",
              int'(out_frac), 0);
        rst_n = 1'b1;
        idle();
        idle();
        check(sb.size() == 0, "R8", "scoreboard drained", sb.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule